// File: doc/BRIEF.md
# LPC Host Cycle Sequencer

This block is the host end of a Low Pin Count bus. A processor-side agent hands it read or write requests of one, two or four bytes, aimed at either I/O space or memory space, through a valid/ready request port. The block turns each request into one or more single-byte LPC target cycles. It drives the frame strobe and the four-bit multiplexed address/data lines itself, and it samples the lines on the clocks when a peripheral owns them.

Every LPC cycle moves exactly one byte. A wider request therefore becomes a run of back-to-back single-byte cycles at rising addresses. The bytes read back are packed into one response word, and only one response is returned, after the last byte cycle ends. A peripheral may fail to answer with a valid handshake nibble within a short window. In that case the host aborts the cycle on the bus and reports 0xFF for that byte. This mimics an idle bus held high by pull-ups.

Top module: `lpc_host_seq`

## Requirements
- R1: While and right after reset, `lframe_n` is 1, `lad_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Each byte cycle opens with exactly one clock of `lframe_n`=0 and `lad_out`=0000 driven. `lframe_n` is low only with `lad_oe`=1 and `lad_out` equal to 0000 or 1111, so the grant codes 0010/0011 are never sent.
- R3: The clock after the opening nibble carries the type/direction code, with `lframe_n`=1: 0000 for an I/O read, 0010 for an I/O write, 0100 for a memory read, 0110 for a memory write.
- R4: The address follows, most significant nibble first. I/O cycles send the low 16 address bits as 4 nibbles. Memory cycles send all 32 bits as 8 nibbles.
- R5: For writes, the data byte follows as low nibble then high nibble. Every cycle then has one clock of 1111 driven by the host, and after that the host releases the lines (`lad_oe`=0) until the cycle ends.
- R6: In the handshake phase, 0000 on `lad_in` means ready, and 0101 or 0110 means wait, for as long as the peripheral keeps sending it. A wait also clears the no-response count. After ready, a read takes the data low nibble, then the high nibble, on the next two clocks. Then two peripheral turnaround clocks end the cycle.
- R7: If the handshake phase sees 4 consecutive clocks of nibbles other than 0000/0101/0110, the host aborts. It drives `lframe_n`=0 with 1111 for exactly 4 clocks, and that byte reads back as 0xFF.
- R8: `req_size` 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes. Byte k is transferred at address `req_addr`+k, in ascending order. For a write, it carries `req_wdata[8k+7:8k]`.
- R9: `rsp_rdata[8k+7:8k]` holds the byte read by cycle k (0xFF if that cycle was aborted). Bytes beyond the request size read zero, and write responses are all zero.
- R10: `req_ready` falls in the clock after acceptance and stays low until the response. `rsp_valid` is a one-clock pulse followed by `req_ready`=1. Requests presented while `req_ready` is low are ignored and start no bus cycle.
- R11: The first byte cycle's opening clock is the second clock after the acceptance edge. Each later byte cycle opens two clocks after the previous one's last clock. `rsp_valid` is high in the clock right after the last byte cycle's final clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_size | input | 2 | Byte count code (0:1, 1:2, 2/3:4) |
| req_addr | input | 32 | Byte address of the first byte |
| req_wdata | input | 32 | Write bytes, byte k in bits 8k+7:8k |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Reassembled read data |
| lframe_n | output | 1 | Active-low cycle frame strobe |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Host drives the bus when 1 |
| lad_in | input | 4 | Nibble sampled from the bus |

## Verification
Nearly every result here has a fixed clock position. The type code is due one clock after the opening nibble, and the address, data and turnaround nibbles follow one per clock. The first handshake sample is taken at the end of the third clock after the last address or data nibble. An abort starts on the fifth clock after the handshake phase opens. The bench's bus model follows the frame one falling edge at a time and sets each peripheral nibble on the falling edge before the sampling edge. It records the clock counter at acceptance and at the last clock of each byte cycle. With those, it checks that the next opening nibble arrives exactly two clocks later and that the response pulse arrives exactly one clock later.

// File: rtl/lpc_host_pkg.sv
package lpc_host_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CTDIR, PH_ADDR, PH_WLO, PH_WHI,
    PH_HTAR0, PH_HTAR1, PH_SYNC, PH_RLO, PH_RHI,
    PH_PTAR0, PH_PTAR1, PH_ABORT
  } bus_phase_t;

  typedef enum logic [1:0] {
    SP_IDLE, SP_ISSUE, SP_WAIT, SP_RESP
  } split_state_t;

  typedef struct packed {
    logic       frame_n;
    logic       oe;
    logic [3:0] nib;
  } bus_drive_t;

  localparam logic [3:0] LAD_START  = 4'h0;
  localparam logic [3:0] LAD_ONES   = 4'hF;
  localparam logic [3:0] SYNC_RDY   = 4'h0;
  localparam logic [3:0] SYNC_SWAIT = 4'h5;
  localparam logic [3:0] SYNC_LWAIT = 4'h6;

  function automatic logic [3:0] cyc_code(input logic is_mem, input logic is_wr);
    return {1'b0, is_mem, is_wr, 1'b0};
  endfunction

endpackage

// File: rtl/lpc_byte_cycle.sv
module lpc_byte_cycle
  import lpc_host_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IO_ADDR_W  = 16,
  parameter int SYNC_LIMIT = 4,
  parameter int ABORT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_mem,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  input  logic [3:0]        lad_in,
  output logic              lframe_n,
  output logic              lad_oe,
  output logic [3:0]        lad_out,
  output logic              done,
  output logic [7:0]        rbyte
);

  localparam int MEM_NIBS = ADDR_W / 4;
  localparam int IO_NIBS  = IO_ADDR_W / 4;
  localparam int NIB_W    = $clog2(MEM_NIBS);
  localparam int TMR_W    = $clog2(SYNC_LIMIT + 1);
  localparam int ABT_W    = $clog2(ABORT_CLKS + 1);
  localparam logic [NIB_W-1:0] MEM_LAST = NIB_W'(MEM_NIBS - 1);
  localparam logic [NIB_W-1:0] IO_LAST  = NIB_W'(IO_NIBS - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SYNC_LIMIT - 1);
  localparam logic [ABT_W-1:0] ABT_LAST = ABT_W'(ABORT_CLKS - 1);

  bus_phase_t        phase_q, phase_n;
  logic [NIB_W-1:0]  nib_q, nib_n;
  logic [TMR_W-1:0]  tmr_q, tmr_n;
  logic [ABT_W-1:0]  abt_q, abt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [7:0]        wb_q, wb_n;
  logic [7:0]        rb_q, rb_n;
  logic              mem_q, mem_n;
  logic              wr_q, wr_n;
  bus_drive_t        drv_q;
  logic              sync_wait;

  function automatic bus_drive_t drive_for(
    input bus_phase_t        ph,
    input logic [NIB_W-1:0]  ni,
    input logic [ADDR_W-1:0] a,
    input logic [7:0]        wb,
    input logic              m,
    input logic              w
  );
    bus_drive_t d;
    d = '{frame_n: 1'b1, oe: 1'b0, nib: LAD_ONES};
    case (ph)
      PH_START: d = '{frame_n: 1'b0, oe: 1'b1, nib: LAD_START};
      PH_CTDIR: d = '{frame_n: 1'b1, oe: 1'b1, nib: cyc_code(m, w)};
      PH_ADDR:  d = '{frame_n: 1'b1, oe: 1'b1, nib: a[ni*4 +: 4]};
      PH_WLO:   d = '{frame_n: 1'b1, oe: 1'b1, nib: wb[3:0]};
      PH_WHI:   d = '{frame_n: 1'b1, oe: 1'b1, nib: wb[7:4]};
      PH_HTAR0: d = '{frame_n: 1'b1, oe: 1'b1, nib: LAD_ONES};
      PH_ABORT: d = '{frame_n: 1'b0, oe: 1'b1, nib: LAD_ONES};
      default:  d = '{frame_n: 1'b1, oe: 1'b0, nib: LAD_ONES};
    endcase
    return d;
  endfunction

  assign sync_wait = (lad_in == SYNC_SWAIT) || (lad_in == SYNC_LWAIT);

  always_comb begin
    phase_n = phase_q;
    nib_n   = nib_q;
    tmr_n   = tmr_q;
    abt_n   = abt_q;
    addr_n  = addr_q;
    wb_n    = wb_q;
    rb_n    = rb_q;
    mem_n   = mem_q;
    wr_n    = wr_q;
    unique case (phase_q)
      PH_IDLE: if (start) begin
        addr_n  = addr;
        wb_n    = wbyte;
        mem_n   = is_mem;
        wr_n    = is_wr;
        phase_n = PH_START;
      end
      PH_START: begin
        nib_n   = mem_q ? MEM_LAST : IO_LAST;
        phase_n = PH_CTDIR;
      end
      PH_CTDIR: phase_n = PH_ADDR;
      PH_ADDR: begin
        if (nib_q == '0) phase_n = wr_q ? PH_WLO : PH_HTAR0;
        else             nib_n   = nib_q - 1'b1;
      end
      PH_WLO:   phase_n = PH_WHI;
      PH_WHI:   phase_n = PH_HTAR0;
      PH_HTAR0: phase_n = PH_HTAR1;
      PH_HTAR1: begin
        tmr_n   = '0;
        phase_n = PH_SYNC;
      end
      PH_SYNC: begin
        if (lad_in == SYNC_RDY) begin
          phase_n = wr_q ? PH_PTAR0 : PH_RLO;
        end else if (sync_wait) begin
          tmr_n = '0;
        end else if (tmr_q == TMR_LAST) begin
          abt_n   = '0;
          rb_n    = 8'hFF;
          phase_n = PH_ABORT;
        end else begin
          tmr_n = tmr_q + 1'b1;
        end
      end
      PH_RLO: begin
        rb_n[3:0] = lad_in;
        phase_n   = PH_RHI;
      end
      PH_RHI: begin
        rb_n[7:4] = lad_in;
        phase_n   = PH_PTAR0;
      end
      PH_PTAR0: phase_n = PH_PTAR1;
      PH_PTAR1: phase_n = PH_IDLE;
      PH_ABORT: begin
        if (abt_q == ABT_LAST) phase_n = PH_IDLE;
        else                   abt_n   = abt_q + 1'b1;
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      nib_q   <= '0;
      tmr_q   <= '0;
      abt_q   <= '0;
      addr_q  <= '0;
      wb_q    <= '0;
      rb_q    <= '0;
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
      drv_q   <= '{frame_n: 1'b1, oe: 1'b0, nib: LAD_ONES};
    end else begin
      phase_q <= phase_n;
      nib_q   <= nib_n;
      tmr_q   <= tmr_n;
      abt_q   <= abt_n;
      addr_q  <= addr_n;
      wb_q    <= wb_n;
      rb_q    <= rb_n;
      mem_q   <= mem_n;
      wr_q    <= wr_n;
      drv_q   <= drive_for(phase_n, nib_n, addr_n, wb_n, mem_n, wr_n);
    end
  end

  assign lframe_n = drv_q.frame_n;
  assign lad_oe   = drv_q.oe;
  assign lad_out  = drv_q.nib;
  assign rbyte    = rb_q;
  assign done     = (phase_q == PH_PTAR1) || ((phase_q == PH_ABORT) && (abt_q == ABT_LAST));

endmodule

// File: rtl/lpc_req_split.sv
module lpc_req_split
  import lpc_host_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_is_mem,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cyc_start,
  output logic              cyc_mem,
  output logic              cyc_wr,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [7:0]        cyc_wbyte,
  input  logic              cyc_done,
  input  logic [7:0]        cyc_rbyte
);

  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  split_state_t      st_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              mem_q, wr_q;
  logic              accept, byte_done;

  function automatic logic [IDX_W-1:0] last_for(input logic [1:0] sz);
    int n;
    n = (1 << sz) - 1;
    if (n > NBYTES - 1) n = NBYTES - 1;
    return IDX_W'(n);
  endfunction

  assign accept    = (st_q == SP_IDLE) && req_valid;
  assign byte_done = (st_q == SP_WAIT) && cyc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SP_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      unique case (st_q)
        SP_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mem_q   <= req_is_mem;
          wr_q    <= req_write;
          idx_q   <= '0;
          last_q  <= last_for(req_size);
          st_q    <= SP_ISSUE;
        end
        SP_ISSUE: st_q <= SP_WAIT;
        SP_WAIT: if (cyc_done) begin
          if (idx_q == last_q) begin
            st_q <= SP_RESP;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= SP_ISSUE;
          end
        end
        SP_RESP: st_q <= SP_IDLE;
        default: st_q <= SP_IDLE;
      endcase
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || accept)                               lane_q <= '0;
      else if (byte_done && (idx_q == IDX_W'(b)))      lane_q <= wr_q ? 8'h00 : cyc_rbyte;
    end
    assign rsp_rdata[8*b +: 8] = lane_q;
  end

  assign req_ready = (st_q == SP_IDLE);
  assign rsp_valid = (st_q == SP_RESP);
  assign cyc_start = (st_q == SP_ISSUE);
  assign cyc_mem   = mem_q;
  assign cyc_wr    = wr_q;
  assign cyc_addr  = addr_q + ADDR_W'(idx_q);
  assign cyc_wbyte = wdata_q[idx_q*8 +: 8];

endmodule

// File: rtl/lpc_host_seq.sv
module lpc_host_seq
  import lpc_host_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int IO_ADDR_W  = 16,
  parameter int SYNC_LIMIT = 4,
  parameter int ABORT_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_is_mem,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              lframe_n,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [3:0]        lad_in
);

  logic              cyc_start, cyc_mem, cyc_wr, cyc_done;
  logic [ADDR_W-1:0] cyc_addr;
  logic [7:0]        cyc_wbyte, cyc_rbyte;

  lpc_req_split #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) split_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_is_mem(req_is_mem),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cyc_start (cyc_start),
    .cyc_mem   (cyc_mem),
    .cyc_wr    (cyc_wr),
    .cyc_addr  (cyc_addr),
    .cyc_wbyte (cyc_wbyte),
    .cyc_done  (cyc_done),
    .cyc_rbyte (cyc_rbyte)
  );

  lpc_byte_cycle #(
    .ADDR_W    (ADDR_W),
    .IO_ADDR_W (IO_ADDR_W),
    .SYNC_LIMIT(SYNC_LIMIT),
    .ABORT_CLKS(ABORT_CLKS)
  ) cyc_i (
    .clk     (clk),
    .rst     (rst),
    .start   (cyc_start),
    .is_mem  (cyc_mem),
    .is_wr   (cyc_wr),
    .addr    (cyc_addr),
    .wbyte   (cyc_wbyte),
    .lad_in  (lad_in),
    .lframe_n(lframe_n),
    .lad_oe  (lad_oe),
    .lad_out (lad_out),
    .done    (cyc_done),
    .rbyte   (cyc_rbyte)
  );

endmodule

// File: rtl/lpc_host_seq_chk.sv
module lpc_host_seq_chk #(
  parameter int ABORT_CLKS = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       lframe_n,
  input logic       lad_oe,
  input logic [3:0] lad_out
);

  localparam int CW = $clog2(ABORT_CLKS + 2) + 1;

  logic [CW-1:0] ab_run;
  logic          in_abort;

  assign in_abort = !lframe_n && lad_oe && (lad_out == 4'hF);

  always_ff @(posedge clk) begin
    if (rst)                          ab_run <= '0;
    else if (in_abort && ab_run != '1) ab_run <= ab_run + 1'b1;
    else if (!in_abort)               ab_run <= '0;
  end

  assert_frame_code_R2: assert property (@(posedge clk) disable iff (rst)
    !lframe_n |-> (lad_oe && (lad_out == 4'h0 || lad_out == 4'hF)));

  assert_start_once_R2: assert property (@(posedge clk) disable iff (rst)
    (!lframe_n && lad_out == 4'h0) |=> lframe_n);

  assert_abort_len_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_abort && ab_run != '0) |-> (ab_run == CW'(ABORT_CLKS)));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

endmodule

bind lpc_host_seq lpc_host_seq_chk #(
  .ABORT_CLKS(ABORT_CLKS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .lframe_n (lframe_n),
  .lad_oe   (lad_oe),
  .lad_out  (lad_out)
);

// File: tb/lpc_host_seq_tb_top.sv
`timescale 1ns/1ps
module lpc_host_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_is_mem = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        lframe_n;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [3:0]  lad_in = 4'hF;

  always #4 clk = ~clk;

  lpc_host_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_is_mem(req_is_mem), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .lframe_n(lframe_n), .lad_out(lad_out),
    .lad_oe(lad_oe), .lad_in(lad_in)
  );

  typedef struct {
    bit          mem;
    bit          wr;
    bit          first;
    bit          claim;
    logic [31:0] addr;
    logic [7:0]  wbyte;
    logic [7:0]  rbyte;
    logic [31:0] pre;
    int          npre;
  } bus_item_t;

  bus_item_t   bus_q[$];
  logic [31:0] rsp_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int end_cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Bus model of the peripheral: follows one byte cycle on falling edges.
  task automatic run_cycle(input bus_item_t it);
    logic [31:0] a, expa;
    logic [7:0]  d;
    bit          okq;
    int          k;
    if (it.first) chk(cyc == acc_cyc + 1, "R11", "first opening after accept", cyc, acc_cyc + 1);
    else          chk(cyc == end_cyc + 2, "R11", "next opening after prior end", cyc, end_cyc + 2);
    @(negedge clk);
    chk(lframe_n && lad_oe && lad_out == {1'b0, it.mem, it.wr, 1'b0}, "R3", "type code",
        {27'd0, lframe_n, lad_out}, {28'd1, 1'b0, it.mem, it.wr, 1'b0});
    a = '0;
    okq = 1'b1;
    for (int i = 0; i < (it.mem ? 8 : 4); i++) begin
      @(negedge clk);
      okq &= lad_oe && lframe_n;
      a = {a[27:0], lad_out};
    end
    expa = it.mem ? it.addr : {16'h0, it.addr[15:0]};
    chk(okq && a == expa, "R4", "address nibbles", a, expa);
    if (it.wr) begin
      @(negedge clk); d[3:0] = lad_out; okq = lad_oe;
      @(negedge clk); d[7:4] = lad_out; okq &= lad_oe;
      chk(okq && d == it.wbyte, "R5", "write data", {24'd0, d}, {24'd0, it.wbyte});
    end
    @(negedge clk);
    chk(lad_oe && lad_out == 4'hF, "R5", "host turnaround ones", {27'd0, lad_oe, lad_out}, 32'h1F);
    @(negedge clk);
    chk(!lad_oe, "R5", "host releases bus", {31'd0, lad_oe}, 32'd0);
    @(negedge clk);
    if (!it.claim) begin
      lad_in = 4'hF;
      okq = !lad_oe && lframe_n;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        okq &= !lad_oe && lframe_n;
      end
      chk(okq, "R7", "no abort before timeout", {31'd0, okq}, 32'd1);
      @(negedge clk);
      k = 0;
      while (!lframe_n && lad_oe && lad_out == 4'hF && k < 16) begin
        k++;
        end_cyc = cyc;
        @(negedge clk);
      end
      chk(k == 4, "R7", "abort clocks", k, 4);
    end else begin
      okq = 1'b1;
      for (int i = 0; i < it.npre; i++) begin
        lad_in = it.pre[4*i +: 4];
        okq &= !lad_oe && lframe_n;
        @(negedge clk);
      end
      lad_in = 4'h0;
      okq &= !lad_oe && lframe_n;
      if (!it.wr) begin
        @(negedge clk); lad_in = it.rbyte[3:0]; okq &= !lad_oe && lframe_n;
        @(negedge clk); lad_in = it.rbyte[7:4]; okq &= !lad_oe && lframe_n;
      end
      @(negedge clk); lad_in = 4'hF; okq &= !lad_oe && lframe_n;
      @(negedge clk); okq &= !lad_oe && lframe_n;
      end_cyc = cyc;
      chk(okq, "R6", "bus released, no abort through handshake", {31'd0, okq}, 32'd1);
    end
    lad_in = 4'hF;
  endtask

  initial begin : periph
    bus_item_t it;
    forever begin
      @(negedge clk);
      if (!rst && !lframe_n && lad_oe && lad_out == 4'h0) begin
        chk(bus_q.size() != 0, "R10", "bus cycle with none expected", 32'd1, 32'd0);
        if (bus_q.size() != 0) begin
          it = bus_q.pop_front();
          run_cycle(it);
        end
      end
    end
  end

  initial begin : rsp_monitor
    logic [31:0] e;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        chk(cyc == end_cyc + 1, "R11", "response clock", cyc, end_cyc + 1);
        if (rsp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", rsp_rdata, 32'd0);
        end else begin
          e = rsp_q.pop_front();
          chk(rsp_rdata == e, "R9", "response data", rsp_rdata, e);
        end
      end
    end
  end

  // Driver: pushes expected bus cycles and the expected response, then issues the request.
  task automatic send(input bit mem, input bit wr, input logic [1:0] size,
                      input logic [31:0] addr, input logic [31:0] wdata,
                      input logic [31:0] rb, input logic [3:0] claim,
                      input logic [31:0] pre, input int npre, input bit poke);
    int n;
    logic [31:0] exp;
    bus_item_t it;
    n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    exp = '0;
    for (int k = 0; k < n; k++) begin
      it.mem   = mem;
      it.wr    = wr;
      it.first = (k == 0);
      it.claim = claim[k];
      it.addr  = addr + k;
      it.wbyte = wdata[8*k +: 8];
      it.rbyte = rb[8*k +: 8];
      it.pre   = pre;
      it.npre  = npre;
      bus_q.push_back(it);
      if (!wr) exp[8*k +: 8] = claim[k] ? rb[8*k +: 8] : 8'hFF;
    end
    rsp_q.push_back(exp);
    @(negedge clk);
    chk(req_ready, "R10", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid  = 1'b1;
    req_write  = wr;
    req_is_mem = mem;
    req_size   = size;
    req_addr   = addr;
    req_wdata  = wdata;
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0;
    chk(!req_ready, "R10", "busy after accept", {31'd0, req_ready}, 32'd0);
    if (poke) begin
      req_valid = 1'b1;
      req_write = 1'b0;
      req_is_mem = 1'b0;
      req_size = 2'd2;
      req_addr = 32'h0000_0080;
      repeat (20) @(negedge clk);
      req_valid = 1'b0;
    end
    while (rsp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(lframe_n == 1'b1, "R1", "frame idle in reset", {31'd0, lframe_n}, 32'd1);
    chk(lad_oe == 1'b0, "R1", "bus released in reset", {31'd0, lad_oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1", "ready, no response after reset",
        {30'd0, req_ready, rsp_valid}, 32'd2);
    chk(lframe_n && !lad_oe, "R1", "bus idle after reset", {30'd0, lframe_n, lad_oe}, 32'd2);

    // R3 R4 R5: single-byte I/O write
    send(1'b0, 1'b1, 2'd0, 32'h0000_0060, 32'h0000_00A5, '0, 4'hF, '0, 0, 1'b0);
    // R6: I/O read with one short wait
    send(1'b0, 1'b0, 2'd0, 32'h0000_0064, '0, 32'h0000_003C, 4'hF, 32'h5, 1, 1'b0);
    // R8 R9: four-byte memory read
    send(1'b1, 1'b0, 2'd2, 32'h000F_FFF0, '0, 32'h4433_2211, 4'hF, 32'h6, 1, 1'b0);
    // R8: two-byte memory write
    send(1'b1, 1'b1, 2'd1, 32'h1234_5678, 32'h0000_BEEF, '0, 4'hF, '0, 0, 1'b0);
    // R7 R9: two-byte I/O read, second byte unclaimed
    send(1'b0, 1'b0, 2'd1, 32'h0000_00FF, '0, 32'h0000_775A, 4'b0001, '0, 0, 1'b0);
    // R7: single memory read unclaimed
    send(1'b1, 1'b0, 2'd0, 32'h0000_1000, '0, 32'h0000_0012, 4'b0000, '0, 0, 1'b0);
    // R6: six long waits exceed the no-response window without aborting
    send(1'b1, 1'b0, 2'd0, 32'h0000_2000, '0, 32'h0000_00C3, 4'hF, 32'h0066_6666, 6, 1'b0);
    // R6 R7: a wait in between clears the invalid-nibble count
    send(1'b0, 1'b0, 2'd0, 32'h0000_0070, '0, 32'h0000_0081, 4'hF, 32'h0999_5999, 7, 1'b0);
    // R10: requests during a busy four-byte memory write are ignored
    send(1'b1, 1'b1, 2'd2, 32'hFFFF_FFF0, 32'hDEAD_C0DE, '0, 4'hF, '0, 0, 1'b1);
    // R8: size code 3 means four bytes
    send(1'b0, 1'b1, 2'd3, 32'h0000_0300, 32'h0403_0201, '0, 4'hF, '0, 0, 1'b0);

    repeat (10) @(negedge clk);
    chk(bus_q.size() == 0, "R8", "all expected byte cycles seen", bus_q.size(), 32'd0);
    chk(rsp_q.size() == 0, "R10", "all responses seen", rsp_q.size(), 32'd0);
    chk(lframe_n && !lad_oe && req_ready, "R10", "idle at end",
        {29'd0, lframe_n, lad_oe, req_ready}, 32'd5);
    finish_run();
  end

endmodule